// File: doc/BRIEF.md
# Adjustable Time-of-Day Counter

This block keeps the local time of day as a seconds count and a nanoseconds count, with 16 extra fractional bits of nanoseconds kept internally. On every reference clock edge it adds a rate increment to the time. When the nanoseconds reach one full second they wrap, the seconds advance, and a one-cycle rollover pulse marks the instant. Every copy of this counter in a timing chain is meant to hold the same value and to roll over together.

A new seconds value may arrive at any moment over a slow control path, because the exact arrival time does not matter. The block holds the value as pending and applies it on the next rising edge of the one-pulse-per-second input. That edge defines the exact start of the new second. A servo outside the block trims the counting rate through a correction that is added to the nominal increment. The correction changes only the counter's arithmetic and never any clock. A three-step stage register follows the servo's commands. The steps are initial load, acquisition (coarse and fine trims allowed) and locked (fine trims only). Writing a new time returns the register to initial load.

Top module: `tod_counter`

## Requirements
- R1: While reset is low and after release, the outputs are seconds 0, nanoseconds 0, rollover 0 and stage 0. The rate correction also starts at 0.
- R2: Each clock edge adds the increment to the time. The increment is NOM_INC (unsigned, in units of 1/65536 ns) plus the signed correction. The nanoseconds output is the integer part of the time below one second.
- R3: When the sum reaches NS_PER_SEC nanoseconds, one second is subtracted and the fraction is kept. The seconds output rises by one and rollover is high for exactly one cycle. The seconds output never changes in a cycle without rollover.
- R4: A cycle with wr_valid high stores wr_sec as pending and leaves the running time unchanged. A later write before the pulse replaces the pending value.
- R5: A rising pps edge loads pending+1 into the seconds and clears the nanoseconds and fraction. A rising edge means pps is high now and was low in the previous cycle. The edge raises rollover and clears the pending value. The load takes precedence over a wrap in the same cycle.
- R6: A rising pps edge with nothing pending has no effect on the time, and neither does pps staying high.
- R7: The stage encoding is 0 = initial load, 1 = acquisition and 2 = locked. Each cycle with stage_adv high moves the stage one step, and locked stays locked.
- R8: wr_valid sets the stage to 0 and overrides stage_adv in the same cycle.
- R9: A trim (trim_valid high) in stage 0 is ignored.
- R10: A coarse trim (trim_fine = 0) in stage 1 replaces the correction with trim_value. In stage 2 a coarse trim is ignored.
- R11: A fine trim (trim_fine = 1) in stage 1 or 2 adds trim_value, shifted right arithmetically by FINE_SHIFT (default 8), to the correction.
- R12: A new correction takes effect from the clock edge after the one that samples the trim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Slow-path time write strobe |
| wr_sec | input | SEC_W | Seconds value to apply at the next pulse |
| pps | input | 1 | One-pulse-per-second input, rising edge used |
| stage_adv | input | 1 | Servo command to advance the stage |
| trim_valid | input | 1 | Rate trim strobe |
| trim_fine | input | 1 | 1 = fine trim (added, shifted), 0 = coarse trim (replace) |
| trim_value | input | CORR_W | Signed trim value, 1/65536 ns units |
| tod_sec | output | SEC_W | Current seconds |
| tod_ns | output | NS_W | Current nanoseconds |
| rollover | output | 1 | One-cycle pulse at the start of each second |
| stage | output | 2 | Acquisition stage |

## Verification
The time, rollover and stage outputs are registered. Each one changes on the first clock edge that samples a write, a pulse edge or a stage command. A rate trim changes the nanoseconds advance only from the second edge, so the trim cycle itself still advances by the old increment. The bench drives inputs on the falling edge and samples each output on the next falling edge. This puts every check exactly one edge after its cause, and the trim checks measure the old-rate step and the new-rate window separately.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_ACQ  = 2'd1,
    ST_LOCK = 2'd2
  } tod_stage_e;
endpackage

// File: rtl/tod_stage_fsm.sv
module tod_stage_fsm
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic       stage_adv,
  output tod_stage_e stage_q
);
  function automatic tod_stage_e next_stage(input tod_stage_e s);
    case (s)
      ST_LOAD: return ST_ACQ;
      ST_ACQ:  return ST_LOCK;
      default: return ST_LOCK;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         stage_q <= ST_LOAD;
    else if (wr_valid)  stage_q <= ST_LOAD;
    else if (stage_adv) stage_q <= next_stage(stage_q);
  end
endmodule

// File: rtl/tod_rate.sv
module tod_rate
  import tod_pkg::*;
#(
  parameter int unsigned ACC_W      = 46,
  parameter int unsigned CORR_W     = 24,
  parameter int unsigned NOM_INC    = 32'd262144,
  parameter int unsigned FINE_SHIFT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trim_valid,
  input  logic                     trim_fine,
  input  logic signed [CORR_W-1:0] trim_value,
  input  tod_stage_e               stage,
  output logic        [ACC_W-1:0]  inc
);
  logic signed [CORR_W-1:0] corr_q;
  logic coarse_ok, fine_ok;

  function automatic logic signed [CORR_W-1:0] fine_step(input logic signed [CORR_W-1:0] v);
    return v >>> FINE_SHIFT;
  endfunction

  function automatic logic [ACC_W-1:0] rate_inc(input logic signed [CORR_W-1:0] c);
    return ACC_W'(NOM_INC) + ACC_W'(c);
  endfunction

  assign coarse_ok = (stage == ST_ACQ);
  assign fine_ok   = (stage == ST_ACQ) || (stage == ST_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_q <= '0;
    end else if (trim_valid) begin
      if (trim_fine && fine_ok)         corr_q <= corr_q + fine_step(trim_value);
      else if (!trim_fine && coarse_ok) corr_q <= trim_value;
    end
  end

  assign inc = rate_inc(corr_q);
endmodule

// File: rtl/tod_pps_load.sv
module tod_pps_load #(
  parameter int unsigned SEC_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pps,
  input  logic             wr_valid,
  input  logic [SEC_W-1:0] wr_sec,
  output logic             pps_load,
  output logic [SEC_W-1:0] load_sec
);
  logic             pps_q;
  logic             pend_q;
  logic [SEC_W-1:0] pend_sec_q;
  logic             pps_rise;

  function automatic logic [SEC_W-1:0] after_pulse(input logic [SEC_W-1:0] s);
    return s + SEC_W'(1);
  endfunction

  assign pps_rise = pps & ~pps_q;
  assign pps_load = pps_rise & pend_q;
  assign load_sec = after_pulse(pend_sec_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pps_q      <= 1'b0;
      pend_q     <= 1'b0;
      pend_sec_q <= '0;
    end else begin
      pps_q <= pps;
      if (wr_valid) begin
        pend_q     <= 1'b1;
        pend_sec_q <= wr_sec;
      end else if (pps_load) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int unsigned SEC_W      = 48,
  parameter int unsigned NS_W       = 30,
  parameter int unsigned FRAC_W     = 16,
  parameter int unsigned NS_PER_SEC = 1000000000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NS_W+FRAC_W-1:0]  inc,
  input  logic                    pps_load,
  input  logic [SEC_W-1:0]        load_sec,
  output logic [SEC_W-1:0]        sec_q,
  output logic [NS_W-1:0]         ns,
  output logic                    roll_q,
  output logic                    wrap
);
  localparam int unsigned ACC_W = NS_W + FRAC_W;
  localparam logic [ACC_W:0] LIMIT = (ACC_W+1)'(NS_PER_SEC) << FRAC_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] acc_adv;

  function automatic logic [ACC_W-1:0] fold(input logic [ACC_W:0] s);
    return (s >= LIMIT) ? ACC_W'(s - LIMIT) : ACC_W'(s);
  endfunction

  assign sum     = {1'b0, acc_q} + {1'b0, inc};
  assign wrap    = (sum >= LIMIT);
  assign acc_adv = fold(sum);
  assign ns      = acc_q[ACC_W-1:FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      sec_q  <= '0;
      roll_q <= 1'b0;
    end else if (pps_load) begin
      acc_q  <= '0;
      sec_q  <= load_sec;
      roll_q <= 1'b1;
    end else begin
      acc_q  <= acc_adv;
      roll_q <= wrap;
      if (wrap) sec_q <= sec_q + SEC_W'(1);
    end
  end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int unsigned SEC_W      = 48,
  parameter int unsigned FRAC_W     = 16,
  parameter int unsigned CORR_W     = 24,
  parameter int unsigned NS_PER_SEC = 1000000000,
  parameter int unsigned NOM_INC    = 32'd262144,
  parameter int unsigned FINE_SHIFT = 8,
  localparam int unsigned NS_W      = $clog2(NS_PER_SEC),
  localparam int unsigned ACC_W     = NS_W + FRAC_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  input  logic        [SEC_W-1:0]  wr_sec,
  input  logic                     pps,
  input  logic                     stage_adv,
  input  logic                     trim_valid,
  input  logic                     trim_fine,
  input  logic signed [CORR_W-1:0] trim_value,
  output logic        [SEC_W-1:0]  tod_sec,
  output logic        [NS_W-1:0]   tod_ns,
  output logic                     rollover,
  output logic        [1:0]        stage
);
  tod_stage_e       stage_q;
  logic [ACC_W-1:0] inc;
  logic             pps_load;
  logic [SEC_W-1:0] load_sec;
  logic             wrap;

  tod_stage_fsm u_stage (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .stage_adv(stage_adv), .stage_q(stage_q)
  );

  tod_rate #(
    .ACC_W(ACC_W), .CORR_W(CORR_W), .NOM_INC(NOM_INC), .FINE_SHIFT(FINE_SHIFT)
  ) u_rate (
    .clk(clk), .rst_n(rst_n), .trim_valid(trim_valid), .trim_fine(trim_fine),
    .trim_value(trim_value), .stage(stage_q), .inc(inc)
  );

  tod_pps_load #(.SEC_W(SEC_W)) u_load (
    .clk(clk), .rst_n(rst_n), .pps(pps), .wr_valid(wr_valid),
    .wr_sec(wr_sec), .pps_load(pps_load), .load_sec(load_sec)
  );

  tod_accum #(
    .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .NS_PER_SEC(NS_PER_SEC)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .inc(inc), .pps_load(pps_load),
    .load_sec(load_sec), .sec_q(tod_sec), .ns(tod_ns),
    .roll_q(rollover), .wrap(wrap)
  );

  assign stage = stage_q;
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
  parameter int unsigned SEC_W      = 48,
  parameter int unsigned NS_W       = 30,
  parameter int unsigned NS_PER_SEC = 1000000000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             stage_adv,
  input logic [SEC_W-1:0] tod_sec,
  input logic [NS_W-1:0]  tod_ns,
  input logic             rollover,
  input logic [1:0]       stage,
  input logic             pps_load,
  input logic             wrap
);
  // R3
  ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tod_ns) < NS_PER_SEC);

  // R3
  roll_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rollover |=> !rollover);

  // R3
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rollover |-> $stable(tod_sec));

  // R3
  wrap_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !pps_load) |=> rollover);

  // R5
  load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pps_load |=> (tod_ns == '0) && rollover);

  // R7
  stage_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_adv && !wr_valid && stage == 2'd1) |=> stage == 2'd2);

  // R7
  stage_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage != 2'd3);

  // R8
  wr_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> stage == 2'd0);
endmodule

bind tod_counter tod_counter_chk #(
  .SEC_W(SEC_W), .NS_W(NS_W), .NS_PER_SEC(NS_PER_SEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .stage_adv(stage_adv),
  .tod_sec(tod_sec), .tod_ns(tod_ns), .rollover(rollover), .stage(stage),
  .pps_load(pps_load), .wrap(wrap)
);

// File: tb/tod_counter_tb.sv
module tod_counter_tb;
  localparam int unsigned SEC_W  = 48;
  localparam int unsigned CORR_W = 24;
  localparam int unsigned NSPS   = 1000;
  localparam int unsigned NS_W   = $clog2(NSPS);
  localparam longint      NOM    = 4 * 65536;
  localparam longint      LIM    = longint'(NSPS) * 65536;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic                     wr_valid = 1'b0;
  logic        [SEC_W-1:0]  wr_sec = '0;
  logic                     pps = 1'b0;
  logic                     stage_adv = 1'b0;
  logic                     trim_valid = 1'b0;
  logic                     trim_fine = 1'b0;
  logic signed [CORR_W-1:0] trim_value = '0;
  logic        [SEC_W-1:0]  tod_sec;
  logic        [NS_W-1:0]   tod_ns;
  logic                     rollover;
  logic        [1:0]        stage;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tod_counter #(.SEC_W(SEC_W), .CORR_W(CORR_W), .NS_PER_SEC(NSPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sec(wr_sec), .pps(pps),
    .stage_adv(stage_adv), .trim_valid(trim_valid), .trim_fine(trim_fine),
    .trim_value(trim_value), .tod_sec(tod_sec), .tod_ns(tod_ns),
    .rollover(rollover), .stage(stage)
  );

  // Behavioural expectation built from the requirements, time as ns*65536+frac
  longint m_sec, m_acc, m_corr, m_pend_sec, m_inc;
  int     m_stage;
  bit     m_pend, m_ppsq, m_roll, m_rise;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_acc = 0; m_corr = 0; m_pend_sec = 0;
      m_stage = 0; m_pend = 0; m_ppsq = 0; m_roll = 0;
    end else begin
      m_inc  = NOM + m_corr;
      m_rise = pps && !m_ppsq;
      m_roll = 0;
      if (m_rise && m_pend) begin
        m_sec = m_pend_sec + 1; m_acc = 0; m_roll = 1; m_pend = 0;
      end else begin
        m_acc = m_acc + m_inc;
        if (m_acc >= LIM) begin m_acc = m_acc - LIM; m_sec = m_sec + 1; m_roll = 1; end
      end
      if (wr_valid) begin m_pend = 1; m_pend_sec = longint'(wr_sec); end
      if (trim_valid) begin
        if (trim_fine && m_stage != 0) m_corr = m_corr + (longint'(trim_value) >>> 8);
        else if (!trim_fine && m_stage == 1) m_corr = longint'(trim_value);
      end
      if (wr_valid) m_stage = 0;
      else if (stage_adv && m_stage < 2) m_stage = m_stage + 1;
      m_ppsq = pps;
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_eq(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_model(input string tag);
    chk_eq(tag, "sec", longint'(tod_sec), m_sec);
    chk_eq(tag, "ns", longint'(tod_ns), m_acc / 65536);
    chk_eq(tag, "rollover", longint'(rollover), longint'(m_roll));
    chk_eq(tag, "stage", longint'(stage), longint'(m_stage));
  endtask

  function automatic longint ns_delta(input longint a, input longint b);
    return (a - b + NSPS) % NSPS;
  endfunction

  task automatic t_reset;
    tick(3);
    // R1: reset state
    chk_eq("R1", "sec", longint'(tod_sec), 0);
    chk_eq("R1", "ns", longint'(tod_ns), 0);
    chk_eq("R1", "rollover", longint'(rollover), 0);
    chk_eq("R1", "stage", longint'(stage), 0);
    rst_n = 1'b1;
    tick();
    chk_eq("R1", "ns after release", longint'(tod_ns), 4);
  endtask

  task automatic t_free_run;
    tick(9);
    // R2: nominal 4 ns per edge
    chk_eq("R2", "ns after 10 edges", longint'(tod_ns), 40);
    chk_model("R2");
  endtask

  task automatic t_wrap;
    int k = 0;
    while (!rollover && k < 400) begin tick(); k++; end
    // R3: wrap lands at exactly one second
    chk_eq("R3", "rollover seen", longint'(rollover), 1);
    chk_eq("R3", "sec at wrap", longint'(tod_sec), 1);
    chk_eq("R3", "ns at wrap", longint'(tod_ns), 0);
    tick();
    chk_eq("R3", "rollover one cycle", longint'(rollover), 0);
    chk_eq("R3", "ns after wrap", longint'(tod_ns), 4);
    chk_model("R3");
  endtask

  task automatic t_load;
    longint s0;
    s0 = longint'(tod_sec);
    wr_valid = 1'b1; wr_sec = 48'd50; tick();
    wr_valid = 1'b0; tick(5);
    wr_valid = 1'b1; wr_sec = 48'd100; tick();
    wr_valid = 1'b0; tick(10);
    // R4: pending write does not touch the running time
    chk_eq("R4", "sec while pending", longint'(tod_sec), s0);
    chk_model("R4");
    pps = 1'b1; tick();
    // R5: load at pulse edge, later write wins
    chk_eq("R5", "sec loaded", longint'(tod_sec), 101);
    chk_eq("R5", "ns cleared", longint'(tod_ns), 0);
    chk_eq("R5", "rollover on load", longint'(rollover), 1);
    tick();
    chk_eq("R5", "ns after load", longint'(tod_ns), 4);
    chk_eq("R5", "rollover after load", longint'(rollover), 0);
    tick(5);
    // R6: pulse held high does not reload
    chk_eq("R6", "ns with pps held", longint'(tod_ns), 24);
    chk_eq("R6", "sec with pps held", longint'(tod_sec), 101);
    pps = 1'b0; tick(11);
    pps = 1'b1; tick();
    // R6: edge with nothing pending is ignored
    chk_eq("R6", "ns at idle edge", longint'(tod_ns), 72);
    chk_eq("R6", "sec at idle edge", longint'(tod_sec), 101);
    chk_model("R6");
    pps = 1'b0; tick();
  endtask

  task automatic t_stage;
    chk_eq("R8", "stage after write", longint'(stage), 0);
    stage_adv = 1'b1; tick();
    chk_eq("R7", "stage to acq", longint'(stage), 1);
    tick();
    chk_eq("R7", "stage to lock", longint'(stage), 2);
    tick();
    chk_eq("R7", "stage stays lock", longint'(stage), 2);
    wr_valid = 1'b1; wr_sec = 48'd7; tick();
    // R8: write beats advance
    chk_eq("R8", "write overrides adv", longint'(stage), 0);
    wr_valid = 1'b0; stage_adv = 1'b0; tick();
    chk_eq("R8", "stage holds load", longint'(stage), 0);
    chk_model("R8");
  endtask

  task automatic t_trim;
    longint n0;
    // R9: trim in load stage ignored
    n0 = longint'(tod_ns);
    trim_valid = 1'b1; trim_fine = 1'b0; trim_value = 24'sd65536; tick();
    trim_valid = 1'b0; tick(10);
    chk_eq("R9", "ns advance", ns_delta(longint'(tod_ns), n0), 44);
    stage_adv = 1'b1; tick(); stage_adv = 1'b0;
    // R10 / R12: coarse +1 ns in acquisition
    n0 = longint'(tod_ns);
    trim_valid = 1'b1; trim_fine = 1'b0; trim_value = 24'sd65536; tick();
    trim_valid = 1'b0;
    chk_eq("R12", "old rate on trim edge", ns_delta(longint'(tod_ns), n0), 4);
    n0 = longint'(tod_ns); tick(10);
    chk_eq("R10", "coarse +1 ns", ns_delta(longint'(tod_ns), n0), 50);
    // R10: coarse replaces, not adds
    trim_valid = 1'b1; trim_value = -24'sd131072; tick();
    trim_valid = 1'b0;
    n0 = longint'(tod_ns); tick(10);
    chk_eq("R10", "coarse replace -2 ns", ns_delta(longint'(tod_ns), n0), 20);
    // R11: fine trims accumulate
    trim_valid = 1'b1; trim_fine = 1'b1; trim_value = 24'sd4194304; tick(2);
    trim_valid = 1'b0; tick(8);
    chk_model("R11");
    stage_adv = 1'b1; tick(); stage_adv = 1'b0;
    chk_eq("R7", "stage lock for trim", longint'(stage), 2);
    // R10: coarse ignored in lock
    trim_valid = 1'b1; trim_fine = 1'b0; trim_value = 24'sd65536; tick();
    trim_valid = 1'b0; tick(9);
    chk_model("R10");
    // R11: fine negative in lock
    trim_valid = 1'b1; trim_fine = 1'b1; trim_value = -24'sd8388608; tick();
    trim_valid = 1'b0; tick(13);
    chk_model("R11");
  endtask

  initial begin
    t_reset();
    t_free_run();
    t_wrap();
    t_load();
    t_stage();
    t_trim();
    tick(300);
    chk_model("R3");
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule